// File: doc/BRIEF.md
# External Interrupt Controller

This block collects up to 32 interrupt sources into one status word and presents a single registered interrupt request to the processor. Nine internal sources are level inputs from on-chip peripherals: a critical input, serial receive and transmit, debug receive and transmit, and four DMA channels. The block mirrors them into status and never latches them. Five external pins pass through a two-flop synchronizer. Each pin is then judged by its own two-bit trigger field, which selects edge or level and the active sense. A small register bus reaches three registers: enable, status (write one to clear) and trigger configuration. Reads return data one cycle after the read strobe.

Software sets enable bits to unmask sources and programs the trigger fields of the external pins. When the request is raised, software reads the pending index, which names the highest-numbered enabled status bit. It then clears external edge events by writing ones to status.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, the enable, status and configuration registers read zero, and `irq` and `pend_vld` are low.
- R2: Register addresses are 0 for enable, 1 for status and 2 for configuration. Enable stores only the implemented positions: 31, 27 down to 20, and 4 down to 0 (mask 0x8FF0001F). Every other enable bit reads zero.
- R3: External pin n has its trigger field at configuration bits [31-2n:30-2n]. The upper bit of the field selects edge (1) or level (0), and the lower bit selects active high or rising (1) versus active low or falling (0). Configuration bits 21 down to 0 read zero.
- R4: In level mode, status bit 4-n equals the synchronized pin n compared with its polarity. A write-one-to-clear leaves a bit set while its level is still active. The bit drops by itself once the pin goes idle.
- R5: In edge mode, the selected edge of synchronized pin n sets status bit 4-n, and the opposite edge does not. The bit stays set after the pin returns to idle.
- R6: Writing status with a 1 clears the matching latched external edge bit, and a 0 leaves it unchanged. Writing all ones clears every latched edge bit.
- R7: Internal source i drives status bit 31 for i=0 and bit 28-i for i=1 to 8, one cycle after the input. Writing ones to status does not change these bits.
- R8: `irq` is the registered OR of status AND enable. A pending source whose enable bit is zero does not raise `irq`.
- R9: `pend_vld` is high exactly when status AND enable is non-zero. `pend_idx` is then the highest set position of that product.
- R10: When an edge sets a status bit in the same cycle that a write-one-to-clear targets that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | 9 | Internal level sources, active high |
| ext_pin | input | 5 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvld |
| bus_rvld | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Combined registered interrupt request |
| pend_idx | output | 5 | Highest enabled pending status position |
| pend_vld | output | 1 | Some enabled status bit is set |

## Verification
The hardest case to reach from the ports is a pin edge and a software clear landing on the same status bit in the same clock cycle. The edge only reaches status after two synchronizer stages plus the edge-detect register. The bench therefore changes the pin on a falling clock edge, waits exactly two cycles, and then issues the clear so that it commits on the same rising edge as the set. Level-mode clears that must not stick are checked by reading status back while the pin is still held active.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int XW = 32;
  localparam int IW = $clog2(XW);

  typedef enum logic [1:0] {
    REG_EN  = 2'd0,
    REG_ST  = 2'd1,
    REG_CFG = 2'd2
  } xirq_reg_e;

  // status position of internal source i
  function automatic int int_bit(input int i);
    return (i == 0) ? XW - 1 : 28 - i;
  endfunction

  // status position of external pin n
  function automatic int ext_bit(input int n, input int num_ext);
    return num_ext - 1 - n;
  endfunction

  function automatic logic [XW-1:0] impl_mask(input int num_int, input int num_ext);
    logic [XW-1:0] m;
    m = '0;
    for (int i = 0; i < num_int; i++) m[int_bit(i)] = 1'b1;
    for (int n = 0; n < num_ext; n++) m[ext_bit(n, num_ext)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic       RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= {W{RST_VAL}};
    end else begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_ext_cell.sv
module xirq_ext_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic pol,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic pend_d;
  logic hit_edge;
  logic hit_lvl;

  always_comb begin
    hit_lvl  = (pin_s == pol);
    hit_edge = pol ? (pin_s & ~prev_q) : (~pin_s & prev_q);
    if (edge_mode) pend_d = (pend & ~clr) | hit_edge;  // a new edge beats the clear
    else           pend_d = hit_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= pin_s;
      pend   <= pend_d;
    end
  end
endmodule

// File: rtl/xirq_prio.sv
module xirq_prio #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          vld
);
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) begin
        idx = IW'(i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_EXT     = 5,
  parameter int NUM_INT     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INT-1:0]  int_src,
  input  logic [NUM_EXT-1:0]  ext_pin,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [XW-1:0]       bus_wdata,
  output logic [XW-1:0]       bus_rdata,
  output logic                bus_rvld,
  output logic                irq,
  output logic [IW-1:0]       pend_idx,
  output logic                pend_vld
);
  localparam int              CFG_W    = 2 * NUM_EXT;
  localparam int              CFG_LSB  = XW - CFG_W;
  localparam logic [XW-1:0]   IMPL     = impl_mask(NUM_INT, NUM_EXT);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // register bus decode
  logic              en_we, cfg_we;
  logic [XW-1:0]     clr_vec;
  logic [XW-1:0]     en_q, en_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;

  always_comb begin
    en_we   = bus_wr && (bus_addr == REG_EN);
    cfg_we  = bus_wr && (bus_addr == REG_CFG);
    clr_vec = (bus_wr && (bus_addr == REG_ST)) ? bus_wdata : '0;
    en_d    = bus_wdata & IMPL;
    cfg_d   = bus_wdata[XW-1:CFG_LSB];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (cfg_we) cfg_q <= cfg_d;
    end
  end

  // external pins
  logic [NUM_EXT-1:0] pin_s;
  logic [NUM_EXT-1:0] st_ext;

  xirq_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (ext_pin),
    .q     (pin_s)
  );

  for (genvar n = 0; n < NUM_EXT; n++) begin : g_ext
    localparam int FLD = 2 * (NUM_EXT - 1 - n);
    xirq_ext_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_sn),
      .pin_s     (pin_s[n]),
      .edge_mode (cfg_q[FLD+1]),
      .pol       (cfg_q[FLD]),
      .clr       (clr_vec[ext_bit(n, NUM_EXT)]),
      .pend      (st_ext[n])
    );
  end

  // internal level sources: mirrored, never cleared
  logic [NUM_INT-1:0] int_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) int_q <= '0;
    else         int_q <= int_src;
  end

  logic [XW-1:0] st_all;
  always_comb begin
    st_all = '0;
    for (int n = 0; n < NUM_EXT; n++) st_all[ext_bit(n, NUM_EXT)] = st_ext[n];
    for (int i = 0; i < NUM_INT; i++) st_all[int_bit(i)] = int_q[i];
  end

  // request and priority
  logic [XW-1:0] act;
  logic          irq_d;
  assign act   = st_all & en_q;
  assign irq_d = |act;

  xirq_prio #(.W(XW), .IW(IW)) u_prio (
    .req (act),
    .idx (pend_idx),
    .vld (pend_vld)
  );

  // registered read port
  logic [XW-1:0] rdata_d;
  always_comb begin
    case (bus_addr)
      REG_EN:  rdata_d = en_q;
      REG_ST:  rdata_d = st_all;
      REG_CFG: rdata_d = {cfg_q, {CFG_LSB{1'b0}}};
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      irq       <= 1'b0;
      bus_rvld  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq      <= irq_d;
      bus_rvld <= bus_rd;
      if (bus_rd) bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
  import xirq_pkg::*;
#(
  parameter int NUM_EXT = 5,
  parameter int NUM_INT = 9
) (
  input logic                 clk,
  input logic                 rst_sn,
  input logic [XW-1:0]        en,
  input logic [XW-1:0]        st,
  input logic [2*NUM_EXT-1:0] cfg,
  input logic [NUM_INT-1:0]   int_src,
  input logic                 bus_wr,
  input logic [1:0]           bus_addr,
  input logic [XW-1:0]        bus_wdata,
  input logic                 irq,
  input logic [IW-1:0]        pend_idx,
  input logic                 pend_vld
);
  localparam logic [XW-1:0] IMPL = impl_mask(NUM_INT, NUM_EXT);

  assert_unused_en_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (en & ~IMPL) == '0);

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (|(st & en)) |=> irq);

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    !(|(st & en)) |=> !irq);

  assert_pend_vld_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    pend_vld == (|(st & en)));

  assert_pend_top_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    pend_vld |-> (((st & en) >> pend_idx) == 32'd1));

  assert_int_on_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    int_src[0] |=> st[XW-1]);

  assert_int_off_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !int_src[0] |=> !st[XW-1]);

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg[2*NUM_EXT-1] && st[NUM_EXT-1]
     && !(bus_wr && bus_addr == REG_CFG)
     && !(bus_wr && bus_addr == REG_ST && bus_wdata[NUM_EXT-1])) |=> st[NUM_EXT-1]);
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .en        (en_q),
  .st        (st_all),
  .cfg       (cfg_q),
  .int_src   (int_src),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .pend_idx  (pend_idx),
  .pend_vld  (pend_vld)
);

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [8:0]  int_src = '0;
  logic [4:0]  ext_pin = 5'h1F;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvld;
  logic        irq;
  logic [4:0]  pend_idx;
  logic        pend_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_ctrl u_xirq_ctrl (
    .clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_pin(ext_pin),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvld(bus_rvld), .irq(irq),
    .pend_idx(pend_idx), .pend_vld(pend_vld)
  );

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endfunction

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (bus_rvld) begin
      if (exp_q.size() == 0) chk("unexpected read data", bus_rdata, 32'hxxxx_xxxx);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(2'd0, 32'h0, "R1 enable after reset");
    rd(2'd2, 32'h0, "R1 config after reset");
    rd(2'd1, 32'h0, "R1 status after reset");
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 pend_vld after reset", {31'b0, pend_vld}, 32'h0);

    // R2 implemented enable bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h8FF0_001F, "R2 enable mask");
    wr(2'd0, 32'h0);

    // R3 configuration field placement
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'hFFC0_0000, "R3 config low bits zero");
    wr(2'd2, 32'hE400_0000); // pin0 rise, pin1 fall, pin2 high, pin3/4 low
    rd(2'd2, 32'hE400_0000, "R3 config readback");
    wr(2'd1, 32'hFFFF_FFFF);
    settle();
    rd(2'd1, 32'h0000_0004, "R4 level high pin2 survives clear");

    // R4 level mode
    ext_pin[2] = 1'b0; settle();
    rd(2'd1, 32'h0, "R4 pin2 idle");
    ext_pin[3] = 1'b0; settle();
    rd(2'd1, 32'h0000_0002, "R4 pin3 active low");
    wr(2'd1, 32'h0000_0002); settle();
    rd(2'd1, 32'h0000_0002, "R4 clear while asserted");
    ext_pin[3] = 1'b1; settle();
    rd(2'd1, 32'h0, "R4 self clear on idle");

    // R5 edge mode
    ext_pin[0] = 1'b0; settle();
    rd(2'd1, 32'h0, "R5 falling ignored in rising mode");
    ext_pin[0] = 1'b1; settle();
    rd(2'd1, 32'h0000_0010, "R5 rising edge latched");
    ext_pin[0] = 1'b0; settle();
    rd(2'd1, 32'h0000_0010, "R5 held after pin idle");
    ext_pin[1] = 1'b0; settle();
    rd(2'd1, 32'h0000_0018, "R5 falling edge pin1");

    // R6 write-one-to-clear
    wr(2'd1, 32'h0000_0008); settle();
    rd(2'd1, 32'h0000_0010, "R6 single clear");
    wr(2'd1, 32'h0); settle();
    rd(2'd1, 32'h0000_0010, "R6 zero write no effect");
    wr(2'd1, 32'hFFFF_FFFF); settle();
    rd(2'd1, 32'h0, "R6 clear all");

    // R7 internal sources
    int_src = 9'h101; settle();
    rd(2'd1, 32'h8010_0000, "R7 critical and dma3");
    wr(2'd1, 32'hFFFF_FFFF); settle();
    rd(2'd1, 32'h8010_0000, "R7 clear ignored");
    int_src = 9'h01E; settle();
    rd(2'd1, 32'h0F00_0000, "R7 serial and debug");

    // R8 / R9 request and priority
    chk("R8 masked no irq", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0200_0000); settle();
    chk("R8 irq on enable", {31'b0, irq}, 32'h1);
    chk("R9 idx single", {27'b0, pend_idx}, 32'd25);
    wr(2'd0, 32'h8FF0_001F); settle();
    chk("R9 idx highest", {27'b0, pend_idx}, 32'd27);
    int_src = '0; settle();
    chk("R8 irq drops", {31'b0, irq}, 32'h0);
    chk("R9 vld drops", {31'b0, pend_vld}, 32'h0);
    ext_pin[0] = 1'b1; settle();
    chk("R9 idx external", {27'b0, pend_idx}, 32'd4);
    chk("R8 irq external", {31'b0, irq}, 32'h1);
    int_src = 9'h100; settle();
    chk("R9 idx dma3 over ext", {27'b0, pend_idx}, 32'd20);
    int_src = '0;
    wr(2'd1, 32'h0000_0010); settle();
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h8FF0_000F);
    ext_pin[0] = 1'b0; settle();
    ext_pin[0] = 1'b1; settle();
    rd(2'd1, 32'h0000_0010, "R8 masked pending still in status");
    chk("R8 masked edge no irq", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h8FF0_001F);
    wr(2'd1, 32'h0000_0010);
    ext_pin[0] = 1'b0; settle();
    rd(2'd1, 32'h0, "R6 clean before collision");

    // R10 set and clear in the same cycle
    @(negedge clk); ext_pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h0000_0010;
    @(negedge clk);
    bus_wr = 1'b0;
    settle();
    rd(2'd1, 32'h0000_0010, "R10 set wins over clear");
    wr(2'd1, 32'h0000_0010); settle();
    rd(2'd1, 32'h0, "R10 later clear works");

    settle();
    if (exp_q.size() != 0) chk("missing read data", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule